// File: doc/BRIEF.md
# Carry-Select Adder

This block adds two unsigned N-bit operands and a carry-in, and produces an N-bit sum and a carry-out. It has no clock. The operands are cut into equal M-bit slices. The lowest slice is one ripple adder that takes the external carry-in. Every slice above it holds two ripple adders: one computes its result assuming an incoming carry of zero, the other assuming an incoming carry of one. Both finish while the lower slices are still settling. When the real carry arrives from the slice below, it only has to steer a multiplexer, which picks that slice's sum bits and its outgoing carry.

The slowest path is the ripple through the lowest slice followed by one multiplexer per higher slice. A slice width near the square root of N keeps that path short. The cost is about twice the area of a single ripple adder. N must be a whole multiple of M. Elaboration stops with an error otherwise.

Top module: `csa_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i, computed as an (N+1)-bit unsigned sum.
- R2: The lowest slice takes cin_i directly. With both operands zero, cin_i = 1 gives sum 1 and cout_o 0, and cin_i = 0 gives sum 0.
- R3: In each higher slice, the carry-one result equals the carry-zero result plus one. The slice outputs the carry-one result when its incoming carry is 1 and the carry-zero result when it is 0.
- R4: A slice whose operand bits are all propagate (sum slice all ones) passes its incoming carry on: carry-out 1 when the incoming carry is 1, and 0 when it is 0.
- R5: The carry selected for the top slice is cout_o. An overflow that starts in the top slice alone sets cout_o.
- R6: With N = 12 and M = 4, adding 0xFFD and 0x011 with cin_i = 0 gives sum 0x00E and cout_o = 1.
- R7: All-ones plus zero with cin_i = 1 carries through every slice, giving sum 0 and cout_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into the lowest bit |
| sum_o | output | N | Sum, modulo 2^N |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The block holds no state. A wrong internal value, such as a stuck carry-one variant or a multiplexer select tied the wrong way, appears at sum_o in the same evaluation. It shows only for operands that drive a carry across the affected slice boundary, so the stimulus has to make carries stop at each boundary and also cross it. Exhaustive 6-bit runs in 2-bit slices cover every boundary case. Directed 12-bit vectors and random 32-bit operands cover the wider configurations.

// File: rtl/csa_pkg.sv
package csa_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

    function automatic int slice_count(input int width, input int slice);
        return width / slice;
    endfunction

endpackage

// File: rtl/csa_ripple_block.sv
module csa_ripple_block #(
    parameter int M = 4
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic         cin_i,
    output logic [M-1:0] sum_o,
    output logic         cout_o
);
    import csa_pkg::*;

    logic [M:0] chain;
    assign chain[0] = cin_i;

    for (genvar i = 0; i < M; i++) begin : g_bit
        fa_out_t fa;
        assign fa          = full_add(a_i[i], b_i[i], chain[i]);
        assign sum_o[i]    = fa.s;
        assign chain[i+1]  = fa.c;
    end

    assign cout_o = chain[M];

    // R1/R2: the gate chain matches arithmetic addition of the slice
    always_comb begin
        assert_ripple_sum_R2: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{M{1'b0}}, cin_i}))
            else $error("ripple slice sum mismatch");
    end
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
    parameter int M = 4
) (
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic         cin_i,
    output logic [M-1:0] sum_o,
    output logic         cout_o
);
    logic [M-1:0] sum_z, sum_o1;
    logic         cy_z, cy_o1;

    csa_ripple_block #(.M(M)) u_assume0 (
        .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(sum_z), .cout_o(cy_z)
    );

    csa_ripple_block #(.M(M)) u_assume1 (
        .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(sum_o1), .cout_o(cy_o1)
    );

    always_comb begin
        if (cin_i) begin
            sum_o  = sum_o1;
            cout_o = cy_o1;
        end else begin
            sum_o  = sum_z;
            cout_o = cy_z;
        end
    end

    // R3: the carry-one variant is the carry-zero variant plus one
    always_comb begin
        assert_variant_step_R3: assert ({cy_o1, sum_o1} == ({cy_z, sum_z} + {{M{1'b0}}, 1'b1}))
            else $error("speculative variants disagree");
    end

    // R4: a carry from the zero variant always implies one from the one variant
    always_comb begin
        assert_carry_monotone_R4: assert (!cy_z || cy_o1)
            else $error("carry-zero variant carries but carry-one does not");
    end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int N = 16,
    parameter int M = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    import csa_pkg::*;

    localparam int NBLK = slice_count(N, M);

    if ((N % M) != 0 || M < 1) begin : g_bad_split
        $error("csa_adder: N must be a positive multiple of M");
    end

    logic [NBLK:0] blk_cy;
    assign blk_cy[0] = cin_i;

    for (genvar k = 0; k < NBLK; k++) begin : g_slice
        if (k == 0) begin : g_base
            csa_ripple_block #(.M(M)) u_base (
                .a_i   (a_i[M-1:0]),
                .b_i   (b_i[M-1:0]),
                .cin_i (blk_cy[0]),
                .sum_o (sum_o[M-1:0]),
                .cout_o(blk_cy[1])
            );
        end else begin : g_sel
            csa_select_block #(.M(M)) u_sel (
                .a_i   (a_i[k*M +: M]),
                .b_i   (b_i[k*M +: M]),
                .cin_i (blk_cy[k]),
                .sum_o (sum_o[k*M +: M]),
                .cout_o(blk_cy[k+1])
            );
        end
    end

    // R5: the carry selected for the top slice drives the adder carry-out
    assign cout_o = blk_cy[NBLK];

    // R1: full-width result equals the arithmetic sum
    always_comb begin
        assert_total_sum_R1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i}))
            else $error("adder result mismatch");
    end
endmodule

// File: tb/sim_csa_adder.sv
module sim_csa_adder;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // 12-bit, 4-bit slices
    logic [11:0] a0, b0, s0;
    logic        c0, co0;
    csa_adder #(.N(12), .M(4)) u0 (.a_i(a0), .b_i(b0), .cin_i(c0), .sum_o(s0), .cout_o(co0));

    // 6-bit, 2-bit slices for exhaustive runs
    logic [5:0] a1, b1, s1;
    logic       c1, co1;
    csa_adder #(.N(6), .M(2)) u1 (.a_i(a1), .b_i(b1), .cin_i(c1), .sum_o(s1), .cout_o(co1));

    // 32-bit, 8-bit slices for random runs
    logic [31:0] a2, b2, s2;
    logic        c2, co2;
    csa_adder #(.N(32), .M(8)) u2 (.a_i(a2), .b_i(b2), .cin_i(c2), .sum_o(s2), .cout_o(co2));

    // {a, b, cin, sum, cout}
    localparam int NVEC = 11;
    localparam logic [37:0] VEC [NVEC] = '{
        {12'hFFD, 12'h011, 1'b0, 12'h00E, 1'b1},  // R6
        {12'h000, 12'h000, 1'b0, 12'h000, 1'b0},  // R2
        {12'h000, 12'h000, 1'b1, 12'h001, 1'b0},  // R2
        {12'hFFF, 12'h000, 1'b1, 12'h000, 1'b1},  // R7
        {12'h00F, 12'h001, 1'b0, 12'h010, 1'b0},  // R3
        {12'h0FF, 12'h001, 1'b0, 12'h100, 1'b0},  // R4 carry passes
        {12'h0F0, 12'h000, 1'b0, 12'h0F0, 1'b0},  // R4 carry held
        {12'h800, 12'h800, 1'b0, 12'h000, 1'b1},  // R5
        {12'h123, 12'h456, 1'b0, 12'h579, 1'b0},  // R1
        {12'hABC, 12'h111, 1'b1, 12'hBCE, 1'b0},  // R1
        {12'h7FF, 12'h001, 1'b0, 12'h800, 1'b0}   // R3
    };

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        a0 = '0; b0 = '0; c0 = 1'b0;
        a1 = '0; b1 = '0; c1 = 1'b0;
        a2 = '0; b2 = '0; c2 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: zero inputs give zero outputs (R2)
        @(negedge clk);
        check("R2 idle", {21'd0, co0, s0}, 33'd0);

        // vector table (R1..R7)
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            {a0, b0, c0} = VEC[i][37:13];
            @(negedge clk);
            check($sformatf("R1 vec%0d", i), {20'd0, co0, s0}, {20'd0, VEC[i][0], VEC[i][12:1]});
        end

        // exhaustive 6-bit in 2-bit slices (R1, R3, R4)
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    @(posedge clk);
                    a1 = 6'(x); b1 = 6'(y); c1 = 1'(ci);
                    @(negedge clk);
                    check("R1 exhaustive", {26'd0, co1, s1}, 33'(x + y + ci));
                end
            end
        end

        // random 32-bit in 8-bit slices (R1)
        for (int r = 0; r < 2000; r++) begin
            logic [32:0] want;
            @(posedge clk);
            a2 = $urandom; b2 = $urandom; c2 = 1'($urandom);
            want = {1'b0, a2} + {1'b0, b2} + {32'd0, c2};
            @(negedge clk);
            check("R1 random", {co2, s2}, want);
        end

        // full 32-bit carry propagation (R7) and top-only overflow (R5)
        @(posedge clk);
        a2 = 32'hFFFF_FFFF; b2 = 32'h0; c2 = 1'b1;
        @(negedge clk);
        check("R7 wide", {co2, s2}, 33'h1_0000_0000);
        @(posedge clk);
        a2 = 32'h8000_0000; b2 = 32'h8000_0000; c2 = 1'b0;
        @(negedge clk);
        check("R5 wide", {co2, s2}, 33'h1_0000_0000);

        finish_run();
    end
endmodule